// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block decides when a sleeping processor core gets its clock back after a power-down request. It runs from a free-running oscillator clock. It watches two active-low external interrupt pins and an active-high reset pin through synchronizers. It drives an oscillator enable, a gate enable for the core clock, an internal core reset, and a one-cycle indication of which interrupt pin caused the wake-up.

An interrupt pin can wake the core in two ways, chosen by a mode bit. In the timed mode, the core clock is released after a start-up count that is loaded from a 16-bit input at the moment of the wake event. In the pin-held mode, the core clock is released only when the waking pin rises again. A rising edge on the reset pin also wakes the core, always in the timed way. When the count expires, the core then receives either a two-cycle reset or a reset that is held for as long as the pin stays high.

Top module: `pd_wake_seq`

## Requirements
- R1: After `rstN` is released, the block is running: `oscEnable`=1, `coreClkEn`=1, `coreReset`=0, `wakeIrq`=0.
- R2: While running, `pdReq` high at a clock edge drops `oscEnable` and `coreClkEn` from that edge onward. `pdReq` has no effect in any other state.
- R3: An interrupt pin can wake the block only when its `irqEnable` bit is 1 and its `irqEdgeSel` bit is 0 (level type). A falling pin with the enable bit at 0, or with the type bit at 1 (edge type), leaves the block asleep.
- R4: Each pin passes through two synchronizing flops. A pin change driven before clock edge k causes the state change at edge k+2.
- R5: With `wakeTimed`=1, a qualified falling edge turns the oscillator on and keeps `coreClkEn` low for exactly `startupLimit`+1 cycles. A value of 0 gives one cycle. The limit is sampled at the wake event, and the pin rising in the meantime does not cancel the wake-up.
- R6: With `wakeTimed`=0, `coreClkEn` stays low after the wake until the same pin that woke the block rises. Edges on the other pin have no effect.
- R7: On the first cycle with `coreClkEn` high after an interrupt wake, `wakeIrq` pulses for one cycle with bit i set for pin i. Bit 0 is `irqPinN[0]`.
- R8: A rising edge on `resetPin` during sleep turns the oscillator on and keeps `coreClkEn` low for `startupLimit`+1 cycles.
- R9: If `resetPin` is low when that count ends, `coreReset` is high for exactly two cycles with `coreClkEn` high. The block is then running, and `wakeIrq` stays 0.
- R10: If `resetPin` is still high when the count ends, `coreReset` and `coreClkEn` stay high until the synchronized pin goes low.
- R11: A reset wake beats an interrupt wake in the same cycle. Between the two interrupt pins, pin 0 beats pin 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| pdReq | input | 1 | Power-down request |
| irqPinN | input | 2 | External interrupt pins, active low |
| irqEnable | input | 2 | Per-pin interrupt enable |
| irqEdgeSel | input | 2 | Per-pin type: 1 = edge, 0 = level |
| wakeTimed | input | 1 | 1 = counter-timed wake, 0 = pin-held wake |
| resetPin | input | 1 | External reset pin, active high |
| startupLimit | input | 16 | Start-up count; cycles gated = value + 1 |
| oscEnable | output | 1 | Oscillator enable |
| coreClkEn | output | 1 | Core clock gate enable |
| coreReset | output | 1 | Internal core reset |
| wakeIrq | output | 2 | One-cycle pulse naming the waking interrupt pin |

## Verification
A wrong sequencer state shows at the ports within one clock. It appears as a wrong oscillator enable, a wrong clock-gate level, or a wrong core reset level, because all three are decoded straight from the state. A start-up count that is off by one shows as the clock gate opening one cycle early or late. A wrong source latch shows only when the clock gate reopens: the `wakeIrq` pulse names the wrong pin, or a reset wake fails to produce the reset pulse. The bench therefore samples at the exact edge where each of these is due.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_TIMED,
    ST_PINWAIT,
    ST_RSTHOLD,
    ST_RSTPULSE
  } wakeState_t;

  // Strobes from the control FSM to the datapath counter
  typedef struct packed {
    logic cntLoad;
    logic cntStep;
  } dpCtl_t;

endpackage

// File: rtl/pd_wake_dp.sv
module pd_wake_dp
  import pd_wake_pkg::*;
#(
  parameter int NUM_IRQ = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqPinN,
  input  logic               resetPin,
  input  logic [CNT_W-1:0]   limitIn,
  input  dpCtl_t             ctl,
  output logic [NUM_IRQ-1:0] irqFall,
  output logic [NUM_IRQ-1:0] irqRise,
  output logic               rstRise,
  output logic               rstLevel,
  output logic               cntDone
);

  localparam int SYNC_D = 3; // two synchronizing flops plus one history flop

  // Interrupt pin synchronizers and edge detectors
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irqSync
    logic [SYNC_D-1:0] shifter;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shifter <= '1;
      else       shifter <= {shifter[SYNC_D-2:0], irqPinN[i]};
    end
    assign irqFall[i] =  shifter[SYNC_D-1] & ~shifter[SYNC_D-2];
    assign irqRise[i] = ~shifter[SYNC_D-1] &  shifter[SYNC_D-2];
  end

  // Reset pin synchronizer
  logic [SYNC_D-1:0] rstShifter;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstShifter <= '0;
    else       rstShifter <= {rstShifter[SYNC_D-2:0], resetPin};
  end
  assign rstLevel = rstShifter[SYNC_D-2];
  assign rstRise  = ~rstShifter[SYNC_D-1] & rstShifter[SYNC_D-2];

  // Start-up counter with a limit latched at the wake event
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      limitQ <= '0;
    end else if (ctl.cntLoad) begin
      cnt    <= '0;
      limitQ <= limitIn;
    end else if (ctl.cntStep) begin
      cnt    <= cnt + 1'b1;
    end
  end
  assign cntDone = (cnt == limitQ);

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntStep |=> (cnt <= limitQ));
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.cntLoad && ctl.cntStep));

endmodule

// File: rtl/pd_wake_fsm.sv
module pd_wake_fsm
  import pd_wake_pkg::*;
#(
  parameter int NUM_IRQ = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdReq,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [NUM_IRQ-1:0] irqEdgeSel,
  input  logic               wakeTimed,
  input  logic [NUM_IRQ-1:0] irqFall,
  input  logic [NUM_IRQ-1:0] irqRise,
  input  logic               rstRise,
  input  logic               rstLevel,
  input  logic               cntDone,
  output dpCtl_t             ctl,
  output logic               oscEnable,
  output logic               coreClkEn,
  output logic               coreReset,
  output logic [NUM_IRQ-1:0] wakeIrq
);

  wakeState_t state, stateNext;
  logic [NUM_IRQ-1:0] srcSel, srcSelNext;
  logic               srcReset, srcResetNext;
  logic               pulseSecond, pulseSecondNext;
  logic [NUM_IRQ-1:0] wakeIrqNext;
  logic [NUM_IRQ-1:0] qualFall, firstFall;

  // Only enabled, level-type pins qualify; the lowest index wins
  assign qualFall  = irqFall & irqEnable & ~irqEdgeSel;
  assign firstFall = qualFall & (~qualFall + 1'b1);

  always_comb begin
    stateNext       = state;
    srcSelNext      = srcSel;
    srcResetNext    = srcReset;
    pulseSecondNext = pulseSecond;
    wakeIrqNext     = '0;
    ctl             = '0;
    unique case (state)
      ST_RUN: begin
        if (pdReq) stateNext = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (rstRise) begin
          stateNext    = ST_TIMED;
          srcResetNext = 1'b1;
          srcSelNext   = '0;
          ctl.cntLoad  = 1'b1;
        end else if (|firstFall) begin
          srcResetNext = 1'b0;
          srcSelNext   = firstFall;
          if (wakeTimed) begin
            stateNext   = ST_TIMED;
            ctl.cntLoad = 1'b1;
          end else begin
            stateNext   = ST_PINWAIT;
          end
        end
      end
      ST_TIMED: begin
        if (cntDone) begin
          if (srcReset) begin
            stateNext       = rstLevel ? ST_RSTHOLD : ST_RSTPULSE;
            pulseSecondNext = 1'b0;
          end else begin
            stateNext   = ST_RUN;
            wakeIrqNext = srcSel;
          end
        end else begin
          ctl.cntStep = 1'b1;
        end
      end
      ST_PINWAIT: begin
        if (|(irqRise & srcSel)) begin
          stateNext   = ST_RUN;
          wakeIrqNext = srcSel;
        end
      end
      ST_RSTHOLD: begin
        if (!rstLevel) stateNext = ST_RUN;
      end
      ST_RSTPULSE: begin
        if (pulseSecond) stateNext = ST_RUN;
        else             pulseSecondNext = 1'b1;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      srcSel      <= '0;
      srcReset    <= 1'b0;
      pulseSecond <= 1'b0;
      wakeIrq     <= '0;
    end else begin
      state       <= stateNext;
      srcSel      <= srcSelNext;
      srcReset    <= srcResetNext;
      pulseSecond <= pulseSecondNext;
      wakeIrq     <= wakeIrqNext;
    end
  end

  assign oscEnable = (state != ST_SLEEP);
  assign coreClkEn = (state == ST_RUN) || (state == ST_RSTHOLD) || (state == ST_RSTPULSE);
  assign coreReset = (state == ST_RSTHOLD) || (state == ST_RSTPULSE);

  assert_pd_stops_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && pdReq) |=> (!oscEnable && !coreClkEn));
  assert_clk_needs_osc_R5: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |-> oscEnable);
  assert_wake_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wakeIrq));
  assert_wake_at_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|wakeIrq) |-> (coreClkEn && !coreReset && $past(!coreClkEn)));
  assert_pulse_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RSTPULSE && pulseSecond) |=> !coreReset);
  assert_reset_clocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |-> coreClkEn);

endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pd_wake_pkg::*;
#(
  parameter int NUM_IRQ = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdReq,
  input  logic [NUM_IRQ-1:0] irqPinN,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [NUM_IRQ-1:0] irqEdgeSel,
  input  logic               wakeTimed,
  input  logic               resetPin,
  input  logic [CNT_W-1:0]   startupLimit,
  output logic               oscEnable,
  output logic               coreClkEn,
  output logic               coreReset,
  output logic [NUM_IRQ-1:0] wakeIrq
);

  dpCtl_t             ctl;
  logic [NUM_IRQ-1:0] irqFall, irqRise;
  logic               rstRise, rstLevel, cntDone;

  pd_wake_dp #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .resetPin(resetPin),
    .limitIn(startupLimit), .ctl(ctl), .irqFall(irqFall), .irqRise(irqRise),
    .rstRise(rstRise), .rstLevel(rstLevel), .cntDone(cntDone)
  );

  pd_wake_fsm #(.NUM_IRQ(NUM_IRQ)) fsm_i (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .irqEnable(irqEnable),
    .irqEdgeSel(irqEdgeSel), .wakeTimed(wakeTimed), .irqFall(irqFall),
    .irqRise(irqRise), .rstRise(rstRise), .rstLevel(rstLevel),
    .cntDone(cntDone), .ctl(ctl), .oscEnable(oscEnable),
    .coreClkEn(coreClkEn), .coreReset(coreReset), .wakeIrq(wakeIrq)
  );

endmodule

// File: tb/pd_wake_seq_tb_top.sv
module pd_wake_seq_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pdReq = 1'b0;
  logic [1:0]  irqPinN = 2'b11;
  logic [1:0]  irqEnable = 2'b11;
  logic [1:0]  irqEdgeSel = 2'b00;
  logic        wakeTimed = 1'b1;
  logic        resetPin = 1'b0;
  logic [15:0] startupLimit = 16'd3;
  logic        oscEnable, coreClkEn, coreReset;
  logic [1:0]  wakeIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_wake_seq dut_i (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .irqPinN(irqPinN),
    .irqEnable(irqEnable), .irqEdgeSel(irqEdgeSel), .wakeTimed(wakeTimed),
    .resetPin(resetPin), .startupLimit(startupLimit), .oscEnable(oscEnable),
    .coreClkEn(coreClkEn), .coreReset(coreReset), .wakeIrq(wakeIrq)
  );

  typedef struct {
    string      tag;
    logic       osc;
    logic       clkEn;
    logic       rst;
    logic [1:0] wake;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: push the expected port values for the current cycle
  task automatic expectNow(input string tag, input logic o, input logic c,
                           input logic r, input logic [1:0] w);
    expItem_t e;
    e.tag = tag; e.osc = o; e.clkEn = c; e.rst = r; e.wake = w;
    expQ.push_back(e);
    -> sampleEv;
  endtask

  // Monitor side: pop and compare against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (oscEnable !== e.osc || coreClkEn !== e.clkEn ||
            coreReset !== e.rst || wakeIrq !== e.wake) begin
          failures++;
          $display("FAIL %s: actual osc=%b clk=%b rst=%b wake=%b expected osc=%b clk=%b rst=%b wake=%b",
                   e.tag, oscEnable, coreClkEn, coreReset, wakeIrq,
                   e.osc, e.clkEn, e.rst, e.wake);
        end
      end
    end
  end

  task automatic goSleep(input string tag);
    pdReq = 1'b1;
    tick(1);
    pdReq = 1'b0;
    expectNow(tag, 1'b0, 1'b0, 1'b0, 2'b00);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expectNow("R1 running after reset", 1, 1, 0, 2'b00);

    // Gated-out pins: edge type on pin 0, disabled pin 1
    irqEdgeSel = 2'b01;
    goSleep("R2 power-down next cycle");
    irqPinN[0] = 1'b0; tick(5);
    expectNow("R3 edge-type pin ignored", 0, 0, 0, 2'b00);
    irqPinN[0] = 1'b1; irqEnable = 2'b01; tick(4);
    irqPinN[1] = 1'b0; tick(5);
    expectNow("R3 disabled pin ignored", 0, 0, 0, 2'b00);
    irqPinN[1] = 1'b1; tick(4);
    irqEnable = 2'b11; irqEdgeSel = 2'b00;

    // Timed wake on pin 0 with limit 3, limit changed after sampling
    irqPinN[0] = 1'b0; tick(3);
    expectNow("R4 wake two sync stages later", 1, 0, 0, 2'b00);
    irqPinN[0] = 1'b1; startupLimit = 16'd100; tick(3);
    expectNow("R5 still gated during count", 1, 0, 0, 2'b00);
    tick(1);
    expectNow("R5 R7 clock back with pin0 pulse", 1, 1, 0, 2'b01);
    tick(1);
    expectNow("R7 pulse lasts one cycle", 1, 1, 0, 2'b00);

    // Timed wake with limit 0 on pin 1
    startupLimit = 16'd0;
    goSleep("R2 second sleep");
    irqPinN[1] = 1'b0; tick(3);
    expectNow("R5 limit zero gated one cycle", 1, 0, 0, 2'b00);
    tick(1);
    expectNow("R5 R7 limit zero release pin1", 1, 1, 0, 2'b10);
    irqPinN[1] = 1'b1; tick(3);

    // Pin-held wake on pin 1
    wakeTimed = 1'b0;
    goSleep("R2 third sleep");
    irqPinN[1] = 1'b0; tick(3);
    expectNow("R6 oscillator on, clock held", 1, 0, 0, 2'b00);
    tick(10);
    expectNow("R6 held while pin low", 1, 0, 0, 2'b00);
    irqPinN[0] = 1'b0; tick(4); irqPinN[0] = 1'b1; tick(4);
    expectNow("R6 other pin ignored", 1, 0, 0, 2'b00);
    pdReq = 1'b1; tick(2);
    expectNow("R2 request ignored while waking", 1, 0, 0, 2'b00);
    pdReq = 1'b0;
    irqPinN[1] = 1'b1; tick(2);
    expectNow("R6 not yet through sync", 1, 0, 0, 2'b00);
    tick(1);
    expectNow("R6 R7 released on same pin rise", 1, 1, 0, 2'b10);

    // Reset wake, pin drops before timeout
    wakeTimed = 1'b1; startupLimit = 16'd5;
    goSleep("R2 fourth sleep");
    resetPin = 1'b1; tick(3);
    expectNow("R8 reset wake starts count", 1, 0, 0, 2'b00);
    resetPin = 1'b0; tick(5);
    expectNow("R8 gated until timeout", 1, 0, 0, 2'b00);
    tick(1);
    expectNow("R9 short reset first cycle", 1, 1, 1, 2'b00);
    tick(1);
    expectNow("R9 short reset second cycle", 1, 1, 1, 2'b00);
    tick(1);
    expectNow("R9 short reset over", 1, 1, 0, 2'b00);

    // Reset wake, pin still high at timeout
    startupLimit = 16'd2;
    goSleep("R2 fifth sleep");
    resetPin = 1'b1; tick(3);
    expectNow("R8 reset wake gated", 1, 0, 0, 2'b00);
    tick(3);
    expectNow("R10 held reset begins", 1, 1, 1, 2'b00);
    tick(4);
    expectNow("R10 reset still held", 1, 1, 1, 2'b00);
    resetPin = 1'b0; tick(2);
    expectNow("R10 held through sync", 1, 1, 1, 2'b00);
    tick(1);
    expectNow("R10 released after pin low", 1, 1, 0, 2'b00);

    // Reset and pin 0 in the same cycle
    startupLimit = 16'd1;
    goSleep("R2 sixth sleep");
    resetPin = 1'b1; irqPinN[0] = 1'b0; tick(3);
    expectNow("R11 simultaneous wake gated", 1, 0, 0, 2'b00);
    resetPin = 1'b0; irqPinN[0] = 1'b1; tick(2);
    expectNow("R11 reset source wins", 1, 1, 1, 2'b00);
    tick(2);
    expectNow("R11 running after reset pulse", 1, 1, 0, 2'b00);

    // Both pins at once, pin-held mode: pin 0 wins
    wakeTimed = 1'b0;
    goSleep("R2 seventh sleep");
    irqPinN = 2'b00; tick(3);
    expectNow("R11 both pins woke", 1, 0, 0, 2'b00);
    irqPinN[1] = 1'b1; tick(3);
    expectNow("R11 pin1 rise does not release", 1, 0, 0, 2'b00);
    irqPinN[0] = 1'b1; tick(3);
    expectNow("R11 R7 pin0 named as source", 1, 1, 0, 2'b01);

    tick(2);
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R1: scoreboard left %0d items, expected 0", expQ.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1: watchdog expired, actual running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule